// File: doc/BRIEF.md
# RMII Nibble Bridge

This block sits on the MAC side of a reduced-pin Ethernet attachment. It translates between a 4-bit internal nibble interface and the 2-bit line interface, and it runs entirely from the one 50 MHz reference clock. All pins are launched and sampled on the rising edge only. On the transmit side it accepts a nibble each time it raises a take strobe. It then places the low dibit and after that the high dibit on the line, and it keeps the line enable high for as long as the frame lasts.

On the receive side the combined carrier/valid pin is read in alternating slots. Even slots give carrier sense and odd slots give data valid. Two consecutive received dibits are joined into a nibble. A collision flag is formed from transmit activity and received carrier when half-duplex operation is selected.

A speed input picks 100 Mbit/s, where every clock is a transfer slot, or 10 Mbit/s, where a free-running divide-by-ten enable makes only every tenth clock a slot. The MAC is expected to change the speed only while no frame is moving in either direction.

Top module: `rmii_nibble_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, all registered outputs (`rmii_txd`, `rmii_tx_en`, `rx_nib`, `rx_nib_vld`, `rx_crs`, `rx_dv`) are cleared. `tx_take` and `col` are low while `rst` is high.
- R2: With `slow_mode` low, every clock is a slot. After a take with `tx_en` high, `rmii_txd` shows nibble bits 1:0 in the following cycle and bits 3:2 in the cycle after that.
- R3: With `slow_mode` high, a modulo-ten counter that runs freely from reset (cleared by reset, value 0 in the first cycle after it) marks a slot only in the cycle where it holds 9. Line outputs and receive outputs change only at the edge that ends a slot cycle, so each value stays for ten cycles.
- R4: `tx_take` is high in a slot cycle where the transmitter is about to send a low dibit. The nibble and `tx_en` are captured at that edge. The high-dibit slot that follows raises no take.
- R5: `rmii_tx_en` takes the value of `tx_en` captured at a take and stays constant through the high-dibit slot. While `rmii_tx_en` is low, `rmii_txd` is 2'b00.
- R6: Receive slots alternate from reset, with the first slot even. In an even slot the sampled `rmii_crs_dv` is registered into `rx_crs`. In an odd slot it is registered into `rx_dv`.
- R7: The `rmii_rxd` value taken in an even slot becomes `rx_nib[1:0]`, and the value taken in the next odd slot becomes `rx_nib[3:2]`. The nibble updates, and `rx_nib_vld` pulses for one cycle, only when `rmii_crs_dv` is high in that odd slot. Otherwise `rx_nib` keeps its value.
- R8: `col` equals `half_duplex AND rmii_tx_en AND rx_crs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_mode | input | 1 | 1 selects 10 Mbit/s, 0 selects 100 Mbit/s |
| half_duplex | input | 1 | Enables the collision flag |
| tx_en | input | 1 | MAC frame-active flag, captured at a take |
| tx_nib | input | 4 | MAC transmit nibble, captured at a take |
| tx_take | output | 1 | Nibble and enable are captured at this edge |
| rmii_txd | output | 2 | Line transmit dibit |
| rmii_tx_en | output | 1 | Line transmit enable |
| rmii_rxd | input | 2 | Line receive dibit |
| rmii_crs_dv | input | 1 | Combined carrier/valid line |
| rx_nib | output | 4 | Assembled receive nibble |
| rx_nib_vld | output | 1 | One-cycle pulse when a new nibble is ready |
| rx_crs | output | 1 | Decoded carrier sense |
| rx_dv | output | 1 | Decoded data valid |
| col | output | 1 | Collision indication |

## Verification
The bench builds the block with its defaults: a prescaler divide of ten and a two-bit line width. These values let the 10 Mbit/s cadence be followed over many whole slot periods. They also let the bench switch speeds in the middle of a run and reset while the counter is mid-count. With a divide of ten, a miscounted divider, a slot taken one cycle early, or swapped dibit halves all show up within a few hundred cycles of random traffic. Both receive slot parities and frames of random length are covered at each speed.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
   typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} tx_phase_t;
   typedef enum logic {SL_CRS = 1'b0, SL_DV = 1'b1} rx_slot_t;
endpackage

// File: rtl/rmb_prescale.sv
module rmb_prescale #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic slow,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("rmb_prescale: DIV must be at least 1");
      end
      if (DIV > 1) begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst)              cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = !rst && (!slow || (cnt == LAST));

         a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
            cnt <= LAST);
         a_r3_slot_spacing: assert property (@(posedge clk) disable iff (rst)
            (slow && tick) |=> (!tick || !slow));
      end else begin : g_nodiv
         assign tick = !rst;
      end
   endgenerate
endmodule

// File: rtl/rmb_tx.sv
module rmb_tx
   import rmb_pkg::*;
#(
   parameter int DW = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic            en_i,
   input  logic [2*DW-1:0] nib_i,
   output logic            take,
   output logic [DW-1:0]   txd_o,
   output logic            txen_o
);
   tx_phase_t     phase;
   logic [DW-1:0] hi_q;

   assign take = tick && (phase == PH_LO);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= PH_LO;
         hi_q   <= '0;
         txd_o  <= '0;
         txen_o <= 1'b0;
      end else if (tick) begin
         if (phase == PH_LO) begin
            if (en_i) begin
               txd_o  <= nib_i[DW-1:0];
               hi_q   <= nib_i[2*DW-1:DW];
               txen_o <= 1'b1;
               phase  <= PH_HI;
            end else begin
               txd_o  <= '0;
               txen_o <= 1'b0;
            end
         end else begin
            txd_o <= hi_q;
            phase <= PH_LO;
         end
      end
   end

   a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(txd_o) && $stable(txen_o)));
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !txen_o |-> (txd_o == '0));
   a_r4_no_double_take: assert property (@(posedge clk) disable iff (rst)
      (take && en_i) |=> !take);
endmodule

// File: rtl/rmb_rx.sv
module rmb_rx
   import rmb_pkg::*;
#(
   parameter int DW = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [DW-1:0]   rxd_i,
   input  logic            crs_dv_i,
   output logic [2*DW-1:0] nib_o,
   output logic            vld_o,
   output logic            crs_o,
   output logic            dv_o
);
   rx_slot_t      slot;
   logic [DW-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot  <= SL_CRS;
         lo_q  <= '0;
         nib_o <= '0;
         vld_o <= 1'b0;
         crs_o <= 1'b0;
         dv_o  <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (tick) begin
            if (slot == SL_CRS) begin
               crs_o <= crs_dv_i;
               lo_q  <= rxd_i;
               slot  <= SL_DV;
            end else begin
               dv_o <= crs_dv_i;
               if (crs_dv_i) begin
                  nib_o <= {rxd_i, lo_q};
                  vld_o <= 1'b1;
               end
               slot <= SL_CRS;
            end
         end
      end
   end

   a_r6_rx_hold: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(crs_o) && $stable(dv_o) && $stable(nib_o)));
   a_r7_vld_with_dv: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> dv_o);
   a_r7_vld_single: assert property (@(posedge clk) disable iff (rst)
      vld_o |=> !vld_o);
endmodule

// File: rtl/rmii_nibble_bridge.sv
module rmii_nibble_bridge #(
   parameter int SLOW_DIV = 10,
   parameter int DIBIT_W  = 2,
   localparam int NIB_W   = 2 * DIBIT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slow_mode,
   input  logic             half_duplex,
   input  logic             tx_en,
   input  logic [NIB_W-1:0] tx_nib,
   output logic             tx_take,
   output logic [DIBIT_W-1:0] rmii_txd,
   output logic             rmii_tx_en,
   input  logic [DIBIT_W-1:0] rmii_rxd,
   input  logic             rmii_crs_dv,
   output logic [NIB_W-1:0] rx_nib,
   output logic             rx_nib_vld,
   output logic             rx_crs,
   output logic             rx_dv,
   output logic             col
);
   generate
      if (DIBIT_W < 1) begin : g_bad_width
         $error("rmii_nibble_bridge: DIBIT_W must be at least 1");
      end
   endgenerate

   logic slot_tick;

   rmb_prescale #(.DIV(SLOW_DIV)) u_pre (
      .clk (clk),
      .rst (rst),
      .slow(slow_mode),
      .tick(slot_tick)
   );

   rmb_tx #(.DW(DIBIT_W)) u_tx (
      .clk   (clk),
      .rst   (rst),
      .tick  (slot_tick),
      .en_i  (tx_en),
      .nib_i (tx_nib),
      .take  (tx_take),
      .txd_o (rmii_txd),
      .txen_o(rmii_tx_en)
   );

   rmb_rx #(.DW(DIBIT_W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .tick    (slot_tick),
      .rxd_i   (rmii_rxd),
      .crs_dv_i(rmii_crs_dv),
      .nib_o   (rx_nib),
      .vld_o   (rx_nib_vld),
      .crs_o   (rx_crs),
      .dv_o    (rx_dv)
   );

   assign col = half_duplex & rmii_tx_en & rx_crs;

   a_r8_col_needs_carrier: assert property (@(posedge clk) disable iff (rst)
      col |-> (rx_crs && rmii_tx_en));
endmodule

// File: tb/rmii_nibble_bridge_tb.sv
module rmii_nibble_bridge_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst = 1'b1, slow_mode = 1'b0, half_duplex = 1'b0, tx_en = 1'b0;
   logic [3:0] tx_nib = '0;
   logic [1:0] rmii_rxd = '0;
   logic       rmii_crs_dv = 1'b0;
   logic       tx_take, rmii_tx_en, rx_nib_vld, rx_crs, rx_dv, col;
   logic [1:0] rmii_txd;
   logic [3:0] rx_nib;

   rmii_nibble_bridge u_dut (
      .clk(clk), .rst(rst), .slow_mode(slow_mode), .half_duplex(half_duplex),
      .tx_en(tx_en), .tx_nib(tx_nib), .tx_take(tx_take),
      .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en),
      .rmii_rxd(rmii_rxd), .rmii_crs_dv(rmii_crs_dv),
      .rx_nib(rx_nib), .rx_nib_vld(rx_nib_vld), .rx_crs(rx_crs),
      .rx_dv(rx_dv), .col(col)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // expected-state model, built from the requirements
   int         m_cnt = 0;
   bit         m_ph = 0, m_txen = 0, m_sel = 0, m_vld = 0, m_crs = 0, m_dv = 0;
   logic [1:0] m_hi = '0, m_txd = '0, m_low = '0;
   logic [3:0] m_nib = '0;

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_tick();
      if (rst) return 1'b0;
      return !slow_mode || (m_cnt == 9);
   endfunction

   task automatic m_update();
      bit t = m_tick();
      if (rst) begin
         m_cnt = 0; m_ph = 0; m_txen = 0; m_sel = 0; m_vld = 0; m_crs = 0; m_dv = 0;
         m_hi = '0; m_txd = '0; m_low = '0; m_nib = '0;
         return;
      end
      m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
      m_vld = 0;
      if (t) begin
         if (!m_ph) begin
            if (tx_en) begin
               m_txd = tx_nib[1:0]; m_hi = tx_nib[3:2]; m_txen = 1; m_ph = 1;
            end else begin
               m_txd = '0; m_txen = 0;
            end
         end else begin
            m_txd = m_hi; m_ph = 0;
         end
         if (!m_sel) begin
            m_crs = rmii_crs_dv; m_low = rmii_rxd;
         end else begin
            m_dv = rmii_crs_dv;
            if (rmii_crs_dv) begin m_nib = {rmii_rxd, m_low}; m_vld = 1; end
         end
         m_sel = !m_sel;
      end
   endtask

   // one clock: check registered outputs, apply inputs, check combinational, advance
   task automatic cycle(bit n_rst, bit n_slow, bit n_hd, bit n_en, logic [3:0] n_nib,
                        logic [1:0] n_rxd, bit n_crsdv);
      @(negedge clk);
      chk("R2/R3/R5", "rmii_txd", {6'd0, rmii_txd}, {6'd0, m_txd});
      chk("R5", "rmii_tx_en", {7'd0, rmii_tx_en}, {7'd0, m_txen});
      chk("R6", "rx_crs", {7'd0, rx_crs}, {7'd0, m_crs});
      chk("R6", "rx_dv", {7'd0, rx_dv}, {7'd0, m_dv});
      chk("R7", "rx_nib", {4'd0, rx_nib}, {4'd0, m_nib});
      chk("R7", "rx_nib_vld", {7'd0, rx_nib_vld}, {7'd0, m_vld});
      rst = n_rst; slow_mode = n_slow; half_duplex = n_hd; tx_en = n_en;
      tx_nib = n_nib; rmii_rxd = n_rxd; rmii_crs_dv = n_crsdv;
      #1;
      chk("R4", "tx_take", {7'd0, tx_take}, {7'd0, m_tick() && !m_ph});
      chk("R8", "col", {7'd0, col}, {7'd0, half_duplex && m_txen && m_crs});
      m_update();
   endtask

   task automatic random_run(int n, bit slow, int en_bias);
      bit en = 0;
      for (int i = 0; i < n; i++) begin
         if (($urandom % 100) < en_bias) en = !en;
         cycle(0, slow, $urandom % 2, en, 4'($urandom), 2'($urandom), $urandom % 2);
      end
      for (int i = 0; i < 40; i++) cycle(0, slow, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      // R1: reset state
      for (int i = 0; i < 4; i++) cycle(1, 0, 1, 1, 4'hF, 2'b11, 1);
      @(negedge clk);
      chk("R1", "rmii_tx_en after reset", {7'd0, rmii_tx_en}, 8'd0);
      chk("R1", "rx_nib after reset", {4'd0, rx_nib}, 8'd0);
      chk("R1", "tx_take in reset", {7'd0, tx_take}, 8'd0);

      // R2: directed low-dibit-first in fast mode, nibble 4'b1011
      cycle(0, 0, 0, 1, 4'hB, 2'b01, 0);
      cycle(0, 0, 0, 0, 4'h0, 2'b10, 1);
      chk("R2", "first dibit", {6'd0, rmii_txd}, 8'h3);
      cycle(0, 0, 0, 0, 4'h0, 2'b00, 0);
      chk("R2", "second dibit", {6'd0, rmii_txd}, 8'h2);
      // R7: directed even 2'b01 then odd 2'b10 with valid -> 4'h9
      cycle(0, 0, 0, 0, 4'h0, 2'b00, 0);
      chk("R7", "assembled nibble", {4'd0, rx_nib}, 8'h9);

      random_run(3000, 0, 10);
      // R3: slow mode, then a reset mid-count, then slow again
      random_run(6000, 1, 3);
      for (int i = 0; i < 4; i++) cycle(0, 1, 0, 0, 0, 0, 0);
      cycle(1, 1, 0, 0, 0, 0, 0);
      random_run(4000, 1, 3);
      // R8: half duplex with carrier held and frames going
      for (int i = 0; i < 400; i++) cycle(0, 0, 1, 1, 4'($urandom), 2'($urandom), 1);
      random_run(2000, 0, 20);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule